// File: doc/BRIEF.md
# Configurable Near/Far Memory-Side Line Cache

This block sits between one requester and two memories: a large, slow far memory and a smaller, fast near memory. A strap sampled while reset is held chooses how the near memory is used until the next reset. It can be an extra addressable window next to far memory, a direct-mapped cache in front of all of far memory, or a split where a quarter or a half of it caches far memory and the rest stays addressable. Every transfer moves one whole line of `LINE_W` bits (64 bytes by default).

Cache tags are not held in a separate array. Each near-memory word carries the line data together with the full far line address it holds, a valid bit and a dirty bit. One near read therefore settles hit or miss. Misses write back a dirty victim, fetch the wanted line from far memory and install it. The controller serves one request at a time and ends each request with a one-cycle completion pulse that carries the line.

Top module: `msc_cache_top`

## Requirements
- R1: The mode strap is captured on every clock edge while `rst_n` is low and then held. The encoding is 0 = flat, 1 = full cache, 2 = hybrid with a quarter of near memory as cache, 3 = hybrid with half as cache. Changing the strap after reset has no effect.
- R2: A request address with bit `FAR_AW` clear targets far line `addr[FAR_AW-1:0]`. With that bit set it targets the near window at offset `o = addr[FAR_AW-1:0]`, which maps to near line `C + o`, where C is the number of cache lines. If `o` is not below `2^NEAR_AW - C`, the request touches no memory: a read returns all zeros and a write is dropped.
- R3: In flat mode a far-region request goes straight to far memory as one access. Near lines are never written with the valid bit set in flat mode.
- R4: Each near word holds the line data in bits `[LINE_W-1:0]`, the far line address in bits `[LINE_W +: FAR_AW]`, the valid bit at `LINE_W+FAR_AW` and the dirty bit one above that. A far-region request in a caching mode uses near line `addr mod C`.
- R5: A read hit (valid, stored address equal) returns the stored line and makes no far access.
- R6: A write hit rewrites the near line with the new data and the dirty bit set.
- R7: On a miss, a valid dirty victim is first written to far memory at its stored address. The wanted line is then read from far memory, including for write misses, and installed valid. The installed line is dirty only for a write, and holds the write data in that case.
- R8: Counted in rising edges after the edge that accepts the request, `rsp_done` rises after 2 cycles per memory access when the memories acknowledge one cycle after request. The access counts are: window miss 0; direct near or far access 1; read hit 1; write hit 2; clean miss 3; dirty miss 4.
- R9: `rsp_done` is a one-cycle pulse with `rsp_data` holding the line (the written data for writes). `req_ready` is high only when idle, and it is high again on the cycle after the pulse.
- R10: At most one of `near_req` and `far_req` is high at a time. A request stays high, with stable address and direction, until its acknowledge.
- R11: In hybrid modes only `addr mod C` lines cache far memory (C = 4 or 8 of 16 by default), and the remaining near lines form the addressable window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 2 | Mode selection sampled during reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write line, 0 = read line |
| req_addr | input | FAR_AW+1 | Line address; top bit selects the near window |
| req_wdata | input | LINE_W | Write line |
| req_ready | output | 1 | Controller idle, request accepted this edge |
| rsp_done | output | 1 | Completion pulse |
| rsp_data | output | LINE_W | Line returned with the pulse |
| near_req | output | 1 | Near memory request |
| near_we | output | 1 | Near memory write |
| near_addr | output | NEAR_AW | Near line address |
| near_wdata | output | LINE_W+FAR_AW+2 | Near word to write (data, address, flags) |
| near_rdata | input | LINE_W+FAR_AW+2 | Near word read, valid with acknowledge |
| near_ack | input | 1 | Near memory acknowledge |
| far_req | output | 1 | Far memory request |
| far_we | output | 1 | Far memory write |
| far_addr | output | FAR_AW | Far line address |
| far_wdata | output | LINE_W | Far line to write |
| far_rdata | input | LINE_W | Far line read, valid with acknowledge |
| far_ack | input | 1 | Far memory acknowledge |

## Verification
Each result is due a fixed number of cycles after acceptance. The memory models acknowledge one cycle after a request, so every access costs two cycles, and a request that touches no memory completes in the cycle right after the accepting edge. From its own model of tags, valid and dirty bits, the bench predicts how many accesses each request takes. It counts rising edges from acceptance, samples `rsp_done` and `rsp_data` on falling edges, and checks that the pulse appears at exactly the predicted count and is low again one cycle later. Write-back contents and installed tag fields are checked in the bench's memory models right after the completing request.

// File: rtl/msc_pkg.sv
// Shared types for the memory-side cache controller.
package msc_pkg;

    // Near-memory usage, taken from the strap during reset.
    typedef enum logic [1:0] {
        MODE_FLAT     = 2'd0,
        MODE_CACHE    = 2'd1,
        MODE_HYB_QTR  = 2'd2,
        MODE_HYB_HALF = 2'd3
    } msc_mode_e;

    // Controller sequencing states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NEAR_DIR,
        ST_FAR_DIR,
        ST_TAG,
        ST_HITWR,
        ST_WBACK,
        ST_FILL,
        ST_INSTALL,
        ST_DONE
    } msc_state_e;

endpackage

// File: rtl/msc_mode_latch.sv
// Captures the mode strap while reset is held and derives the near-memory
// split. Assumes the near memory holds a power of two lines (2**NEAR_AW),
// at least four.
module msc_mode_latch
    import msc_pkg::*;
#(
    parameter int NEAR_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_strap,
    output msc_mode_e          mode_q,
    output logic [NEAR_AW:0]   cache_lines,
    output logic [NEAR_AW:0]   flat_lines
);
    localparam logic [NEAR_AW:0] NEAR_LINES = (NEAR_AW+1)'(1) << NEAR_AW;

    // Sample the strap on every reset edge, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= msc_mode_e'(mode_strap);
        end
    end

    // Size the cache part for the held mode; the remainder is addressable.
    always_comb begin
        case (mode_q)
            MODE_CACHE:    cache_lines = NEAR_LINES;
            MODE_HYB_QTR:  cache_lines = NEAR_LINES >> 2;
            MODE_HYB_HALF: cache_lines = NEAR_LINES >> 1;
            default:       cache_lines = '0;
        endcase
        flat_lines = NEAR_LINES - cache_lines;
    end

endmodule

// File: rtl/msc_addr_map.sv
// Splits a request address into the far region or the near window, and
// computes the near line used for a window access or a cache lookup.
// Assumes FAR_AW >= NEAR_AW and a power-of-two cache size.
module msc_addr_map #(
    parameter int NEAR_AW = 4,
    parameter int FAR_AW  = 6
) (
    input  logic [FAR_AW:0]    addr,
    input  logic [NEAR_AW:0]   cache_lines,
    input  logic [NEAR_AW:0]   flat_lines,
    output logic               is_window,
    output logic               window_ok,
    output logic [NEAR_AW-1:0] window_line,
    output logic               cache_on,
    output logic [NEAR_AW-1:0] cache_index
);
    logic [FAR_AW-1:0]  offset;
    logic [NEAR_AW-1:0] index_mask;

    // Region select, window bounds and set index.
    always_comb begin
        offset      = addr[FAR_AW-1:0];
        is_window   = addr[FAR_AW];
        window_ok   = (FAR_AW+1)'(offset) < (FAR_AW+1)'(flat_lines);
        window_line = cache_lines[NEAR_AW-1:0] + offset[NEAR_AW-1:0];
        cache_on    = cache_lines != '0;
        index_mask  = cache_lines[NEAR_AW-1:0] - NEAR_AW'(1);
        cache_index = offset[NEAR_AW-1:0] & index_mask;
    end

endmodule

// File: rtl/msc_line_fsm.sv
// Sequences one request at a time through tag read, write-back, fill and
// install, or a direct near/far access. Assumes the memories hold their
// request until acknowledge and present read data with the acknowledge.
module msc_line_fsm
    import msc_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int NEAR_AW = 4,
    parameter int FAR_AW  = 6,
    parameter int NW      = LINE_W + FAR_AW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [FAR_AW:0]    req_addr,
    input  logic [LINE_W-1:0]  req_wdata,
    input  logic               dec_window,
    input  logic               dec_window_ok,
    input  logic [NEAR_AW-1:0] dec_window_line,
    input  logic               dec_cache_on,
    input  logic [NEAR_AW-1:0] dec_index,
    output logic               req_ready,
    output logic               rsp_done,
    output logic [LINE_W-1:0]  rsp_data,
    output logic               near_req,
    output logic               near_we,
    output logic [NEAR_AW-1:0] near_addr,
    output logic [NW-1:0]      near_wdata,
    input  logic [NW-1:0]      near_rdata,
    input  logic               near_ack,
    output logic               far_req,
    output logic               far_we,
    output logic [FAR_AW-1:0]  far_addr,
    output logic [LINE_W-1:0]  far_wdata,
    input  logic [LINE_W-1:0]  far_rdata,
    input  logic               far_ack
);
    localparam int VLD_BIT = LINE_W + FAR_AW;
    localparam int DRT_BIT = VLD_BIT + 1;

    msc_state_e         st;
    logic               we_q;
    logic [FAR_AW-1:0]  addr_q;
    logic [LINE_W-1:0]  wdata_q;
    logic [NEAR_AW-1:0] idx_q;
    logic [NEAR_AW-1:0] wline_q;
    logic [NW-1:0]      vic_q;
    logic [LINE_W-1:0]  rsp_q;
    logic               hit;

    // Tag compare against the word returned by the tag read.
    always_comb begin
        hit = near_rdata[VLD_BIT] && (near_rdata[LINE_W +: FAR_AW] == addr_q);
    end

    // Request acceptance and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
            wline_q <= '0;
            vic_q   <= '0;
            rsp_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    we_q    <= req_we;
                    addr_q  <= req_addr[FAR_AW-1:0];
                    wdata_q <= req_wdata;
                    idx_q   <= dec_index;
                    wline_q <= dec_window_line;
                    if (dec_window) begin
                        if (dec_window_ok) begin
                            st <= ST_NEAR_DIR;
                        end else begin
                            rsp_q <= '0;
                            st    <= ST_DONE;
                        end
                    end else if (dec_cache_on) begin
                        st <= ST_TAG;
                    end else begin
                        st <= ST_FAR_DIR;
                    end
                end
                ST_NEAR_DIR: if (near_ack) begin
                    rsp_q <= we_q ? wdata_q : near_rdata[LINE_W-1:0];
                    st    <= ST_DONE;
                end
                ST_FAR_DIR: if (far_ack) begin
                    rsp_q <= we_q ? wdata_q : far_rdata;
                    st    <= ST_DONE;
                end
                ST_TAG: if (near_ack) begin
                    vic_q <= near_rdata;
                    if (hit) begin
                        if (we_q) begin
                            st <= ST_HITWR;
                        end else begin
                            rsp_q <= near_rdata[LINE_W-1:0];
                            st    <= ST_DONE;
                        end
                    end else if (near_rdata[VLD_BIT] && near_rdata[DRT_BIT]) begin
                        st <= ST_WBACK;
                    end else begin
                        st <= ST_FILL;
                    end
                end
                ST_HITWR: if (near_ack) begin
                    rsp_q <= wdata_q;
                    st    <= ST_DONE;
                end
                ST_WBACK: if (far_ack) begin
                    st <= ST_FILL;
                end
                ST_FILL: if (far_ack) begin
                    rsp_q <= we_q ? wdata_q : far_rdata;
                    st    <= ST_INSTALL;
                end
                ST_INSTALL: if (near_ack) begin
                    st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Request-side outputs.
    always_comb begin
        req_ready = st == ST_IDLE;
        rsp_done  = st == ST_DONE;
        rsp_data  = rsp_q;
    end

    // Near-memory port drive.
    always_comb begin
        near_req  = st inside {ST_NEAR_DIR, ST_TAG, ST_HITWR, ST_INSTALL};
        near_we   = (st == ST_NEAR_DIR && we_q) || st == ST_HITWR || st == ST_INSTALL;
        near_addr = (st == ST_NEAR_DIR) ? wline_q : idx_q;
        case (st)
            ST_NEAR_DIR: near_wdata = {2'b00, FAR_AW'(0), wdata_q};
            ST_HITWR:    near_wdata = {1'b1, 1'b1, addr_q, wdata_q};
            ST_INSTALL:  near_wdata = {we_q, 1'b1, addr_q, rsp_q};
            default:     near_wdata = '0;
        endcase
    end

    // Far-memory port drive.
    always_comb begin
        far_req   = st inside {ST_FAR_DIR, ST_WBACK, ST_FILL};
        far_we    = st == ST_WBACK || (st == ST_FAR_DIR && we_q);
        far_addr  = (st == ST_WBACK) ? vic_q[LINE_W +: FAR_AW] : addr_q;
        far_wdata = (st == ST_WBACK) ? vic_q[LINE_W-1:0] : wdata_q;
    end

endmodule

// File: rtl/msc_cache_top.sv
// Memory-side cache controller top: mode latch, address map and line
// sequencer. Near words carry data, far line address, valid and dirty.
// Assumes FAR_AW >= NEAR_AW >= 2.
module msc_cache_top
    import msc_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int NEAR_AW = 4,
    parameter int FAR_AW  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 mode_strap,
    input  logic                       req_valid,
    input  logic                       req_we,
    input  logic [FAR_AW:0]            req_addr,
    input  logic [LINE_W-1:0]          req_wdata,
    output logic                       req_ready,
    output logic                       rsp_done,
    output logic [LINE_W-1:0]          rsp_data,
    output logic                       near_req,
    output logic                       near_we,
    output logic [NEAR_AW-1:0]         near_addr,
    output logic [LINE_W+FAR_AW+1:0]   near_wdata,
    input  logic [LINE_W+FAR_AW+1:0]   near_rdata,
    input  logic                       near_ack,
    output logic                       far_req,
    output logic                       far_we,
    output logic [FAR_AW-1:0]          far_addr,
    output logic [LINE_W-1:0]          far_wdata,
    input  logic [LINE_W-1:0]          far_rdata,
    input  logic                       far_ack
);
    localparam int NW = LINE_W + FAR_AW + 2;

    msc_mode_e          mode_q;
    logic [NEAR_AW:0]   cache_lines;
    logic [NEAR_AW:0]   flat_lines;
    logic               dec_window;
    logic               dec_window_ok;
    logic [NEAR_AW-1:0] dec_window_line;
    logic               dec_cache_on;
    logic [NEAR_AW-1:0] dec_index;

    msc_mode_latch #(.NEAR_AW(NEAR_AW)) mode_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_strap  (mode_strap),
        .mode_q      (mode_q),
        .cache_lines (cache_lines),
        .flat_lines  (flat_lines)
    );

    msc_addr_map #(.NEAR_AW(NEAR_AW), .FAR_AW(FAR_AW)) map_i (
        .addr        (req_addr),
        .cache_lines (cache_lines),
        .flat_lines  (flat_lines),
        .is_window   (dec_window),
        .window_ok   (dec_window_ok),
        .window_line (dec_window_line),
        .cache_on    (dec_cache_on),
        .cache_index (dec_index)
    );

    msc_line_fsm #(.LINE_W(LINE_W), .NEAR_AW(NEAR_AW), .FAR_AW(FAR_AW), .NW(NW)) fsm_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_we          (req_we),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .dec_window      (dec_window),
        .dec_window_ok   (dec_window_ok),
        .dec_window_line (dec_window_line),
        .dec_cache_on    (dec_cache_on),
        .dec_index       (dec_index),
        .req_ready       (req_ready),
        .rsp_done        (rsp_done),
        .rsp_data        (rsp_data),
        .near_req        (near_req),
        .near_we         (near_we),
        .near_addr       (near_addr),
        .near_wdata      (near_wdata),
        .near_rdata      (near_rdata),
        .near_ack        (near_ack),
        .far_req         (far_req),
        .far_we          (far_we),
        .far_addr        (far_addr),
        .far_wdata       (far_wdata),
        .far_rdata       (far_rdata),
        .far_ack         (far_ack)
    );

endmodule

// File: rtl/msc_cache_chk.sv
// Protocol and layout checks for msc_cache_top, attached by bind.
// Assumes the memories acknowledge only while a request is high.
module msc_cache_chk
    import msc_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int NEAR_AW = 4,
    parameter int FAR_AW  = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input msc_mode_e                mode_q,
    input logic [NEAR_AW:0]         cache_lines,
    input logic                     req_ready,
    input logic                     rsp_done,
    input logic                     near_req,
    input logic                     near_we,
    input logic [NEAR_AW-1:0]       near_addr,
    input logic [LINE_W+FAR_AW+1:0] near_wdata,
    input logic                     near_ack,
    input logic                     far_req,
    input logic                     far_we,
    input logic [FAR_AW-1:0]        far_addr,
    input logic                     far_ack
);
    localparam int VLD_BIT = LINE_W + FAR_AW;

    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(near_req && far_req)); // R10
    AST_NEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        near_req && !near_ack |=> near_req && $stable(near_addr) && $stable(near_we)); // R10
    AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        far_req && !far_ack |=> far_req && $stable(far_addr) && $stable(far_we)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done && req_ready); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready); // R9
    AST_FLAT_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_FLAT && near_req && near_we |-> !near_wdata[VLD_BIT]); // R3
    AST_CACHE_LINE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        near_req && near_we && ((NEAR_AW+1)'(near_addr) < cache_lines) |-> near_wdata[VLD_BIT]); // R4

endmodule

bind msc_cache_top msc_cache_chk #(.LINE_W(LINE_W), .NEAR_AW(NEAR_AW), .FAR_AW(FAR_AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .cache_lines (cache_lines),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .near_req    (near_req),
    .near_we     (near_we),
    .near_addr   (near_addr),
    .near_wdata  (near_wdata),
    .near_ack    (near_ack),
    .far_req     (far_req),
    .far_we      (far_we),
    .far_addr    (far_addr),
    .far_ack     (far_ack)
);

// File: tb/msc_cache_top_tb.sv
// Bench: sweeps every far line and every window offset in all four modes,
// predicting data and completion cycle from a model of tags and flags.
module msc_cache_top_tb_top;
    localparam int  LINE_W  = 512;
    localparam int  NEAR_AW = 4;
    localparam int  FAR_AW  = 6;
    localparam int  NW      = LINE_W + FAR_AW + 2;
    localparam int  NEARN   = 1 << NEAR_AW;
    localparam int  FARN    = 1 << FAR_AW;
    localparam int  VLD_BIT = LINE_W + FAR_AW;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_strap = 2'd0;
    logic              req_valid = 1'b0;
    logic              req_we = 1'b0;
    logic [FAR_AW:0]   req_addr = '0;
    logic [LINE_W-1:0] req_wdata = '0;
    logic              req_ready, rsp_done;
    logic [LINE_W-1:0] rsp_data;
    logic              near_req, near_we, near_ack;
    logic [NEAR_AW-1:0] near_addr;
    logic [NW-1:0]     near_wdata, near_rdata;
    logic              far_req, far_we, far_ack;
    logic [FAR_AW-1:0] far_addr;
    logic [LINE_W-1:0] far_wdata, far_rdata;

    logic [NW-1:0]     near_mem [NEARN];
    logic [LINE_W-1:0] far_mem  [FARN];

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msc_cache_top #(.LINE_W(LINE_W), .NEAR_AW(NEAR_AW), .FAR_AW(FAR_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .near_req(near_req), .near_we(near_we), .near_addr(near_addr),
        .near_wdata(near_wdata), .near_rdata(near_rdata), .near_ack(near_ack),
        .far_req(far_req), .far_we(far_we), .far_addr(far_addr),
        .far_wdata(far_wdata), .far_rdata(far_rdata), .far_ack(far_ack)
    );

    function automatic logic [LINE_W-1:0] pat(int a, int seed);
        logic [LINE_W-1:0] v;
        for (int k = 0; k < LINE_W/32; k++)
            v[k*32 +: 32] = 32'(32'h9E3779B9 * (a + 1)) ^ 32'(seed << 24) ^ 32'(k * 257);
        return v;
    endfunction

    // Memory models: acknowledge one cycle after request, cleared in reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            near_ack <= 1'b0;
            far_ack  <= 1'b0;
            for (int i = 0; i < NEARN; i++) near_mem[i] <= '0;
            for (int i = 0; i < FARN; i++) far_mem[i] <= pat(i, 0);
        end else begin
            near_ack <= near_req && !near_ack;
            far_ack  <= far_req && !far_ack;
            if (near_req && !near_ack) begin
                if (near_we) near_mem[near_addr] <= near_wdata;
                near_rdata <= near_mem[near_addr];
            end
            if (far_req && !far_ack) begin
                if (far_we) far_mem[far_addr] <= far_wdata;
                far_rdata <= far_mem[far_addr];
            end
            if (near_req && far_req) overlaps++;
        end
    end

    task automatic chk_line(string tag, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_num(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Bench-side model of logical contents and cache state.
    logic [LINE_W-1:0] fshadow [FARN];
    logic [LINE_W-1:0] nshadow [NEARN];
    int  ctag [NEARN];
    bit  cval [NEARN];
    bit  cdrt [NEARN];
    int  cl;

    task automatic do_reset(int m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_strap = 2'(m);
        case (m)
            1: cl = NEARN;
            2: cl = NEARN / 4;
            3: cl = NEARN / 2;
            default: cl = 0;
        endcase
        for (int i = 0; i < FARN; i++) fshadow[i] = pat(i, 0);
        for (int i = 0; i < NEARN; i++) begin
            nshadow[i] = '0; cval[i] = 0; cdrt[i] = 0; ctag[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_num("R9 reset ready", req_ready, 1);
        chk_num("R9 reset done", rsp_done, 0);
    endtask

    // One request: predict access count and data, run, then compare.
    task automatic op(string pfx, bit we, int addr, logic [LINE_W-1:0] d);
        int n, c, victim, idx, off;
        bit evict, inst;
        logic [LINE_W-1:0] exp;
        string path;
        evict = 0; inst = 0; victim = 0; idx = 0;
        if (addr >= FARN) begin
            off = addr - FARN;
            path = "R2";
            if (off < NEARN - cl) begin
                n = 1;
                exp = we ? d : nshadow[off];
                if (we) nshadow[off] = d;
            end else begin
                n = 0;
                exp = '0;
            end
        end else if (cl == 0) begin
            path = "R3";
            n = 1;
            exp = we ? d : fshadow[addr];
            if (we) fshadow[addr] = d;
        end else begin
            idx = addr % cl;
            if (cval[idx] && ctag[idx] == addr) begin
                n = we ? 2 : 1;
                path = we ? "R6" : "R5";
                if (we) cdrt[idx] = 1;
            end else begin
                evict = cval[idx] && cdrt[idx];
                victim = ctag[idx];
                n = evict ? 4 : 3;
                path = "R7";
                ctag[idx] = addr; cval[idx] = 1; cdrt[idx] = we;
                inst = 1;
            end
            if (cl < NEARN) path = {path, " R11"};
            exp = we ? d : fshadow[addr];
            if (we) fshadow[addr] = d;
        end
        chk_num({pfx, path, " R9 ready before request"}, req_ready, 1);
        req_valid = 1'b1; req_we = we; req_addr = (FAR_AW+1)'(addr); req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        c = 0;
        while (!rsp_done && c < 60) begin
            @(posedge clk);
            @(negedge clk);
            c++;
        end
        chk_num({pfx, path, " R8 completion cycle"}, c, 2 * n);
        chk_line({pfx, path, " data"}, rsp_data, exp);
        if (evict) chk_line({pfx, "R7 write-back content"}, far_mem[victim], fshadow[victim]);
        if (path == "R3" && we) chk_line({pfx, "R3 far written"}, far_mem[addr], d);
        if (inst) begin
            chk_num({pfx, "R4 stored address"}, near_mem[idx][LINE_W +: FAR_AW], addr);
            chk_num({pfx, "R4 valid bit"}, near_mem[idx][VLD_BIT], 1);
            chk_num({pfx, "R4 dirty bit"}, near_mem[idx][VLD_BIT+1], we);
        end
        @(posedge clk);
        @(negedge clk);
        chk_num({pfx, "R9 pulse ends"}, rsp_done, 0);
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            do_reset(m);
            for (int a = 0; a < FARN; a++) op("", 0, a, '0);
            for (int a = 0; a < FARN; a += 3) op("", 1, a, pat(a, m + 1));
            for (int a = 0; a < FARN; a++) op("", 0, a, '0);
            op("", 0, 5, '0);
            op("", 0, 5, '0);
            for (int o = 0; o < NEARN + 4; o++) begin
                op("", 1, FARN + o, pat(o, m + 9));
                op("", 0, FARN + o, '0);
            end
            mode_strap = 2'((m + 1) % 4);
            for (int a = 0; a < 8; a++) op("R1 strap ignored ", 0, a, '0);
            op("R1 strap ignored ", 0, FARN + NEARN - 1, '0);
        end
        chk_num("R10 simultaneous requests", overlaps, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule